// File: doc/BRIEF.md
# Mapped Register File

This block is the register file of a small 16-bit processor. It holds a 32-slot address space that three 5-bit fields select. Two ports read it at the same time and one port writes it. Most slots are plain storage. A fixed set of slots does something else: one is a constant zero, one is an output latch that can be written but not read back, one returns pseudo-random numbers, and several drive outputs of the block.

The slots that drive outputs are four general-purpose I/O registers, three pointer registers for the stack and memory units, and the program-counter slot. The sequencing unit reads the program counter through a dedicated output. It can also load a new program counter through a dedicated update input, for example to advance it by one instruction. A jump is a normal register-file write to the program-counter slot.

Both read ports are combinational. Writes take effect on the rising clock edge, and a synchronous active-high reset clears every writable slot.

Top module: `mapped_regfile`

## Requirements
- R1: Slot 0 reads as 0 on both ports, and a write to slot 0 has no effect.
- R2: Slots 1, 2, 3, 4, 7, 8, 13 and 14 are storage. A written value reads back on both read ports until the slot is written again.
- R3: Slot 5 is write-only. `out_val` shows the last value written to it, and a read of slot 5 returns 0.
- R4: Slots 9 through 12 are readable and writable I/O registers. `gpio_o` carries slot 9 in bits [15:0], slot 10 in [31:16], slot 11 in [47:32] and slot 12 in [63:48].
- R5: Slot 16 (stack pointer), slot 17 (stack location) and slot 19 (memory pointer) are readable and writable. Their values drive `stk_ptr_o`, `stk_loc_o` and `mem_ptr_o` respectively.
- R6: Slot 6 is the program counter, shown on `pc_o`. It can be read and written. When `pc_step_en` is high and the same cycle does not write slot 6, the counter loads `pc_step_val`. A register-file write to slot 6 takes priority over the step.
- R7: Slot 15 reads a 16-bit pseudo-random state that advances on every clock that is not in reset. Each step shifts the state left by one bit and puts bit15^bit13^bit12^bit10 into bit 0. Reset loads the seed 16'hACE1. A write to slot 15 has no effect.
- R8: Slots 18 and 20 through 31 are unmapped. They read as 0, and writes to them are dropped.
- R9: Reads are combinational. A read of a slot in the same cycle that slot is being written returns the old value, and the new value appears after the rising edge.
- R10: A synchronous reset sets every writable slot, and every output driven from one, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A slot |
| rd_data_a | output | 16 | Read port A data |
| rd_addr_b | input | 5 | Read port B slot |
| rd_data_b | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write slot |
| wr_data | input | 16 | Write data |
| pc_step_en | input | 1 | Program-counter update request from the sequencing unit |
| pc_step_val | input | 16 | Program-counter value to load on an update |
| pc_o | output | 16 | Current program counter |
| out_val | output | 16 | Output latch (slot 5) |
| gpio_o | output | 64 | The four I/O registers, packed |
| stk_ptr_o | output | 16 | Stack pointer |
| stk_loc_o | output | 16 | Stack location |
| mem_ptr_o | output | 16 | Memory pointer |

## Verification
The bench writes a distinct value to all 32 slots and then reads every slot on both ports, computing the expected value from the slot's class. If the map were decoded wrong, a constant, unmapped or write-only slot would echo stored data, or a storage slot would lose its value. It also checks the random slot against an arithmetic model of the shift sequence after a write to that slot, so a random source that can be overwritten or that stalls shows up as a mismatch. It tests the case where a jump write and a step request hit the program counter in the same cycle, and it checks that a read in the same cycle as a write returns the old value. A wrong priority or a read that forwards the new value would show the other value.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    localparam int ADDR_W  = 5;
    localparam int NSLOT   = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] A_ZERO  = 5'd0;
    localparam logic [ADDR_W-1:0] A_OUT   = 5'd5;
    localparam logic [ADDR_W-1:0] A_PC    = 5'd6;
    localparam logic [ADDR_W-1:0] A_IO0   = 5'd9;
    localparam logic [ADDR_W-1:0] A_RAND  = 5'd15;
    localparam logic [ADDR_W-1:0] A_SPTR  = 5'd16;
    localparam logic [ADDR_W-1:0] A_SLOC  = 5'd17;
    localparam logic [ADDR_W-1:0] A_MPTR  = 5'd19;
    localparam int                N_IO    = 4;

    typedef enum logic [2:0] {
        K_ZERO,
        K_STORE,
        K_OUTL,
        K_PC,
        K_RAND,
        K_NONE
    } slot_kind_e;

    function automatic slot_kind_e slot_kind(logic [ADDR_W-1:0] a);
        slot_kind_e k;
        case (a)
            5'd0:                          k = K_ZERO;
            5'd1, 5'd2, 5'd3, 5'd4,
            5'd7, 5'd8, 5'd13, 5'd14:      k = K_STORE;
            5'd9, 5'd10, 5'd11, 5'd12:     k = K_STORE;
            5'd16, 5'd17, 5'd19:           k = K_STORE;
            5'd5:                          k = K_OUTL;
            5'd6:                          k = K_PC;
            5'd15:                         k = K_RAND;
            default:                       k = K_NONE;
        endcase
        return k;
    endfunction

    function automatic logic slot_writable(slot_kind_e k);
        return (k == K_STORE) || (k == K_OUTL) || (k == K_PC);
    endfunction

    function automatic logic slot_readable(slot_kind_e k);
        return (k == K_STORE) || (k == K_PC);
    endfunction

endpackage

// File: rtl/regmap_lfsr.sv
module regmap_lfsr #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] state
);
    logic fb;

    assign fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= {state[WIDTH-2:0], fb};
    end

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/regmap_store.sv
module regmap_store
    import regmap_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     pc_step_en,
    input  logic [DATA_W-1:0]        pc_step_val,
    output logic [DATA_W-1:0]        slot_q [NSLOT]
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] ME = ADDR_W'(i);
        localparam slot_kind_e        KIND = slot_kind(ME);

        if (KIND == K_PC) begin : g_pc
            logic [DATA_W-1:0] q;
            logic              hit;
            assign hit = wr_en && (wr_addr == ME);
            always_ff @(posedge clk) begin
                if (rst)             q <= '0;
                else if (hit)        q <= wr_data;
                else if (pc_step_en) q <= pc_step_val;
            end
            assign slot_q[i] = q;
        end else if (slot_writable(KIND)) begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                          q <= '0;
                else if (wr_en && wr_addr == ME)  q <= wr_data;
            end
            assign slot_q[i] = q;
        end else begin : g_tie
            assign slot_q[i] = '0;
        end
    end

    logic primed;
    always_ff @(posedge clk) primed <= !rst;

    // R6
    pc_step_load_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(pc_step_en && !(wr_en && wr_addr == A_PC)) |-> slot_q[A_PC] == $past(pc_step_val));

    // R6
    pc_write_wins_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(wr_en && wr_addr == A_PC) |-> slot_q[A_PC] == $past(wr_data));

    // R3
    out_hold_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        $past(!(wr_en && wr_addr == A_OUT)) |-> $stable(slot_q[A_OUT]));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) && primed == 1'b0 && $past(primed) == 1'b0 |-> slot_q[A_PC] == '0 || $isunknown($past(rst)));

endmodule

// File: rtl/regmap_rdport.sv
module regmap_rdport
    import regmap_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] slot_q [NSLOT],
    input  logic [DATA_W-1:0] rand_q,
    output logic [DATA_W-1:0] data
);
    slot_kind_e kind;

    always_comb begin
        kind = slot_kind(addr);
        unique case (kind)
            K_STORE, K_PC: data = slot_q[addr];
            K_RAND:        data = rand_q;
            default:       data = '0;
        endcase
    end

    // R1 R3 R8
    hidden_reads_zero_chk: assert final (
        !(kind inside {K_ZERO, K_OUTL, K_NONE}) || data == '0);

endmodule

// File: rtl/mapped_regfile.sv
module mapped_regfile
    import regmap_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] RND_TAPS = 16'hB400,
    parameter logic [DATA_W-1:0] RND_SEED = 16'hACE1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [4:0]               rd_addr_a,
    output logic [DATA_W-1:0]        rd_data_a,
    input  logic [4:0]               rd_addr_b,
    output logic [DATA_W-1:0]        rd_data_b,
    input  logic                     wr_en,
    input  logic [4:0]               wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     pc_step_en,
    input  logic [DATA_W-1:0]        pc_step_val,
    output logic [DATA_W-1:0]        pc_o,
    output logic [DATA_W-1:0]        out_val,
    output logic [4*DATA_W-1:0]      gpio_o,
    output logic [DATA_W-1:0]        stk_ptr_o,
    output logic [DATA_W-1:0]        stk_loc_o,
    output logic [DATA_W-1:0]        mem_ptr_o
);
    localparam int NRD = 2;

    logic [DATA_W-1:0] slot_q [NSLOT];
    logic [DATA_W-1:0] rand_q;
    logic [ADDR_W-1:0] rd_addr [NRD];
    logic [DATA_W-1:0] rd_data [NRD];

    regmap_lfsr #(.WIDTH(DATA_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_rand (
        .clk   (clk),
        .rst   (rst),
        .state (rand_q)
    );

    regmap_store #(.DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pc_step_en  (pc_step_en),
        .pc_step_val (pc_step_val),
        .slot_q      (slot_q)
    );

    assign rd_addr[0] = rd_addr_a;
    assign rd_addr[1] = rd_addr_b;

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        regmap_rdport #(.DATA_W(DATA_W)) u_port (
            .addr   (rd_addr[p]),
            .slot_q (slot_q),
            .rand_q (rand_q),
            .data   (rd_data[p])
        );
    end

    assign rd_data_a = rd_data[0];
    assign rd_data_b = rd_data[1];

    for (genvar g = 0; g < N_IO; g++) begin : g_io
        assign gpio_o[g*DATA_W +: DATA_W] = slot_q[A_IO0 + ADDR_W'(g)];
    end

    assign pc_o      = slot_q[A_PC];
    assign out_val   = slot_q[A_OUT];
    assign stk_ptr_o = slot_q[A_SPTR];
    assign stk_loc_o = slot_q[A_SLOC];
    assign mem_ptr_o = slot_q[A_MPTR];

    // R1
    zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == A_ZERO) |-> rd_data_a == '0);

    // R5
    sptr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == A_SPTR) |-> rd_data_b == stk_ptr_o);

endmodule

// File: tb/mapped_regfile_bench.sv
module mapped_regfile_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  rd_addr_a = 0, rd_addr_b = 0, wr_addr = 0;
    logic [15:0] rd_data_a, rd_data_b, wr_data = 0, pc_step_val = 0;
    logic        wr_en = 0, pc_step_en = 0;
    logic [15:0] pc_o, out_val, stk_ptr_o, stk_loc_o, mem_ptr_o;
    logic [63:0] gpio_o;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [15:0] exp_q [32];
    logic [15:0] rnd_m;

    always #2 clk = ~clk;

    mapped_regfile u_mapped_regfile (
        .clk(clk), .rst(rst),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pc_step_en(pc_step_en), .pc_step_val(pc_step_val), .pc_o(pc_o),
        .out_val(out_val), .gpio_o(gpio_o),
        .stk_ptr_o(stk_ptr_o), .stk_loc_o(stk_loc_o), .mem_ptr_o(mem_ptr_o)
    );

    // R7 reference sequence
    always @(posedge clk) begin
        if (rst) rnd_m <= 16'hACE1;
        else     rnd_m <= {rnd_m[14:0], rnd_m[15] ^ rnd_m[13] ^ rnd_m[12] ^ rnd_m[10]};
    end

    function automatic bit is_store(int a);
        return (a >= 1 && a <= 4) || a == 7 || a == 8 || a == 13 || a == 14 ||
               (a >= 9 && a <= 12) || a == 16 || a == 17 || a == 19;
    endfunction

    function automatic bit can_write(int a);
        return is_store(a) || a == 5 || a == 6;
    endfunction

    function automatic logic [15:0] exp_read(int a);
        if (a == 15) return rnd_m;
        if (is_store(a) || a == 6) return exp_q[a];
        return 16'h0;
    endfunction

    function automatic string req_of(int a);
        if (a == 0) return "R1";
        if (a == 5) return "R3";
        if (a == 6) return "R6";
        if (a == 15) return "R7";
        if (a >= 9 && a <= 12) return "R4";
        if (a == 16 || a == 17 || a == 19) return "R5";
        if (is_store(a)) return "R2";
        return "R8";
    endfunction

    task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic write_slot(int a, logic [15:0] d);
        wr_en = 1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (can_write(a)) exp_q[a] = d;
    endtask

    task automatic check_all_reads(string tag);
        for (int a = 0; a < 32; a++) begin
            rd_addr_a = 5'(a); rd_addr_b = 5'(31 - a);
            #0.5;
            check(req_of(a), {tag, " port A"}, rd_data_a, exp_read(a));
            check(req_of(31 - a), {tag, " port B"}, rd_data_b, exp_read(31 - a));
            @(negedge clk);
        end
    endtask

    task automatic check_outputs(string tag);
        #0.5;
        check("R3", {tag, " out_val"}, out_val, exp_q[5]);
        check("R6", {tag, " pc_o"}, pc_o, exp_q[6]);
        for (int g = 0; g < 4; g++)
            check("R4", {tag, " gpio slice"}, gpio_o[g*16 +: 16], exp_q[9 + g]);
        check("R5", {tag, " stk_ptr"}, stk_ptr_o, exp_q[16]);
        check("R5", {tag, " stk_loc"}, stk_loc_o, exp_q[17]);
        check("R5", {tag, " mem_ptr"}, mem_ptr_o, exp_q[19]);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 32; a++) exp_q[a] = 16'h0;
        @(negedge clk); @(negedge clk);
        // R10 reset state, R7 seed
        check_all_reads("reset");
        check_outputs("reset");
        rst = 0;

        // R2 R3 R4 R5 R6 R8 R1 R7: write every slot, read all back
        for (int a = 0; a < 32; a++)
            write_slot(a, 16'(a * 16'h0101) ^ 16'h5A3C);
        check_all_reads("sweep1");
        check_outputs("sweep1");

        // second pattern, bit-inverted
        for (int a = 31; a >= 0; a--)
            write_slot(a, ~(16'(a * 16'h0101) ^ 16'h5A3C));
        check_all_reads("sweep2");
        check_outputs("sweep2");

        // R7: write to the random slot then follow the sequence for several cycles
        write_slot(15, 16'h0000);
        rd_addr_a = 5'd15;
        for (int k = 0; k < 6; k++) begin
            #0.5;
            check("R7", "random step", rd_data_a, rnd_m);
            @(negedge clk);
        end

        // R9: read during write returns old value, then the new one
        rd_addr_a = 5'd3;
        wr_en = 1; wr_addr = 5'd3; wr_data = 16'hC0DE;
        #0.5;
        check("R9", "read during write", rd_data_a, exp_q[3]);
        @(negedge clk);
        wr_en = 0; exp_q[3] = 16'hC0DE;
        #0.5;
        check("R9", "read after write", rd_data_a, 16'hC0DE);

        // R6: step alone loads the update value
        @(negedge clk);
        pc_step_en = 1; pc_step_val = 16'h1234;
        @(negedge clk);
        pc_step_en = 0; exp_q[6] = 16'h1234;
        rd_addr_b = 5'd6;
        #0.5;
        check("R6", "pc step", pc_o, 16'h1234);
        check("R6", "pc step read", rd_data_b, 16'h1234);
        // R6: write and step together, write wins
        @(negedge clk);
        pc_step_en = 1; pc_step_val = 16'h1111;
        write_slot(6, 16'h0BEE);
        pc_step_en = 0;
        #0.5;
        check("R6", "pc write priority", pc_o, 16'h0BEE);

        // R10: reset again clears every writable slot
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        for (int a = 0; a < 32; a++) exp_q[a] = 16'h0;
        check_all_reads("reset2");
        check_outputs("reset2");
        rst = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule